// File: doc/BRIEF.md
# SPI Serial SRAM Slave Controller

This block is the serial front end of a byte-addressed on-chip memory. An external SPI master selects it with an active-low chip select, clocks opcodes, addresses and data in on SI, and receives read data and status on SO. Memory reads and writes run at bus speed with no wait states. While chip select stays low, a burst continues from one address to the next and wraps from the top address back to zero. Bus modes 0 and 3 are both accepted: SI is taken on the rising SCK edge and SO moves on the falling edge.

All serial pins are sampled in the system clock domain through a configurable synchronizer, so SCK must run several times slower than the system clock. Writes need a write-enable latch, which the master sets and clears with dedicated opcodes. Two protect bits in a small status byte guard none, the top quarter, the top half or all of the array. A write-protect pin locks that status byte. A hold pin freezes the serial state mid-transfer. Two further opcodes only raise one-cycle request pulses for a separate nonvolatile save/restore sequencer.

The array depth is a parameter. The full-size part uses 17 address bits. The default build is smaller so that elaboration stays light.

Top module: `sram_spi_slave`

## Requirements
- R1: After reset, SO is undriven (so_oe low), no request pulse is raised, and a status read returns 0x00.
- R2: Opcode 0x02 (write) takes three address bytes, MSB first, of which only the low ADDR_W bits are used. Each later full data byte is stored at the current address when the write-enable latch is set. The address then steps by one and wraps from the top address to 0.
- R3: Opcode 0x03 (read) takes three address bytes. Bit 7 of the addressed byte is on SO from the falling SCK edge after the last address bit. Bytes follow MSB first with the same step-and-wrap rule.
- R4: Opcode 0x0B (fast read) takes three address bytes and one dummy byte, during which SO is undriven, and then streams data as in R3.
- R5: Mode 0 (SCK idle low) and mode 3 (SCK idle high) give identical results.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch also clears when chip select rises to end a write or status-write transaction. With the latch clear, write data leaves the array unchanged.
- R7: Opcode 0x05 returns the status byte, repeated for every further byte. The status byte is {4'b0000, prot[1:0], wel, 1'b0}, with prot in bits 3:2 and wel in bit 1. Opcode 0x01 loads prot from bits 3:2 of the next byte when the latch is set and wp_n is high.
- R8: The prot value 00 protects nothing, 01 protects the top quarter (two address MSBs = 11), 10 protects the top half (address MSB = 1) and 11 protects the whole array. Protected bytes are not written, and the burst address keeps stepping.
- R9: With wp_n low, a status write leaves the prot bits unchanged.
- R10: While hold_n is low, SO is undriven and SCK and SI edges are ignored. After release, the transfer resumes exactly where it stopped.
- R11: A rising chip select ends any transaction and discards a partial byte. A partial opcode has no effect, and a partial data byte is not stored.
- R12: An unrecognised opcode is ignored. SO stays undriven until chip select rises.
- R13: Opcode 0x3C raises store_req and opcode 0x60 raises recall_req, each for exactly one clock cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause serial activity when low |
| wp_ni | input | 1 | Status-write lock when low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (pad is high-impedance when low) |
| store_req_o | output | 1 | One-cycle request to save the array |
| recall_req_o | output | 1 | One-cycle request to restore the array |

## Verification
A corrupted bit counter or phase shows up within one byte as a shifted or misaligned SO byte, or as a data byte stored at the wrong place. A wrong address counter shows up on the next burst byte, most sharply at the wrap from the top address to zero. A stuck write-enable latch or a wrong protect decode only shows when the array is read back. For that reason the bench sweeps the whole small array after every protect level and compares every byte against an arithmetic pattern. A hold that fails to freeze the state shows as a byte whose lower half is shifted.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_WRDI   = 8'h04;
   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_WRSR   = 8'h01;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_FREAD  = 8'h0B;
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_STORE  = 8'h3C;
   localparam logic [7:0] OP_RECALL = 8'h60;

   typedef enum logic [2:0] {
      PH_OPC,
      PH_ADDR,
      PH_DUMMY,
      PH_WDATA,
      PH_RDATA,
      PH_SRD,
      PH_SRW,
      PH_IDLE
   } phase_t;

   typedef enum logic [1:0] {
      AC_READ,
      AC_FREAD,
      AC_WRITE
   } access_t;

endpackage

// File: rtl/sram_spi_sync.sv
module sram_spi_sync #(
   parameter int                 WIDTH   = 5,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("sram_spi_sync: STAGES must lie in 0..4");
      end

      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  stg_q[g] <= RST_VAL;
               end else if (g == 0) begin
                  stg_q[g] <= d_i;
               end else begin
                  stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
               end
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sram_spi_guard.sv
module sram_spi_guard #(
   parameter int ADDR_W = 11
) (
   input  logic [1:0]        prot_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              locked_o
);

   localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1,  {(ADDR_W-1){1'b0}}};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sram_spi_guard: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      unique case (prot_i)
         2'b00:   locked_o = 1'b0;
         2'b01:   locked_o = (addr_i >= QTR_BASE);
         2'b10:   locked_o = (addr_i >= HALF_BASE);
         default: locked_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/sram_spi_array.sv
module sram_spi_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) begin
         cell_q[addr_i] <= wdata_i;
      end
      rdata_o <= cell_q[addr_i];
   end

endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave
   import sram_spi_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_ni,
   input  logic sck_i,
   input  logic si_i,
   input  logic hold_ni,
   input  logic wp_ni,
   output logic so_o,
   output logic so_oe_o,
   output logic store_req_o,
   output logic recall_req_o
);

   localparam int                AW       = ADDR_W;
   localparam int                PIN_N    = 5;
   localparam logic [PIN_N-1:0]  PIN_RST  = 5'b10011;
   localparam logic [AW-1:0]     ADDR_TOP = {AW{1'b1}};

   generate
      if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr
         $error("sram_spi_slave: ADDR_W must lie in 4..24");
      end
   endgenerate

   // pin synchronizer: {cs, hold, sck, si, wp}
   logic [PIN_N-1:0] pin_raw, pin_s;
   logic             cs_s, hold_s, sck_s, si_s, wp_s;

   assign pin_raw = {cs_ni, hold_ni, sck_i, si_i, wp_ni};

   sram_spi_sync #(
      .WIDTH   (PIN_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_raw),
      .q_o    (pin_s)
   );

   assign {cs_s, hold_s, sck_s, si_s, wp_s} = pin_s;

   // edge detection
   logic sck_q, cs_q;
   logic active, sck_rise, sck_fall, cs_rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
      end
   end

   assign active   = !cs_s && hold_s;
   assign sck_rise = active &&  sck_s && !sck_q;
   assign sck_fall = active && !sck_s &&  sck_q;
   assign cs_rise  = cs_s && !cs_q;

   // serial state
   phase_t        phase;
   access_t       acc;
   logic [2:0]    bit_cnt;
   logic [6:0]    sh_in;
   logic [7:0]    out_sh;
   logic          out_live;
   logic [1:0]    abyte_cnt;
   logic [AW-1:0] addr_q;
   logic          wel_q;
   logic [1:0]    prot_q;
   logic          wr_seen;
   logic          store_q, recall_q;

   logic [7:0]    byte_in;
   logic          byte_done;
   logic [7:0]    status;
   logic          locked;
   logic          mem_we;
   logic [7:0]    mem_rdata;
   logic          addr_inc;
   logic          out_phase;

   assign byte_in   = {sh_in, si_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);
   assign status    = {4'b0000, prot_q, wel_q, 1'b0};
   assign addr_inc  = byte_done && (phase == PH_WDATA || phase == PH_RDATA);
   assign mem_we    = byte_done && (phase == PH_WDATA) && wel_q && !locked;
   assign out_phase = (phase == PH_RDATA) || (phase == PH_SRD);

   sram_spi_guard #(
      .ADDR_W (AW)
   ) guard_i (
      .prot_i   (prot_q),
      .addr_i   (addr_q),
      .locked_o (locked)
   );

   sram_spi_array #(
      .ADDR_W (AW),
      .DATA_W (8)
   ) array_i (
      .clk_i   (clk_i),
      .we_i    (mem_we),
      .addr_i  (addr_q),
      .wdata_i (byte_in),
      .rdata_o (mem_rdata)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase     <= PH_OPC;
         acc       <= AC_READ;
         bit_cnt   <= '0;
         sh_in     <= '0;
         out_sh    <= '0;
         out_live  <= 1'b0;
         abyte_cnt <= '0;
         addr_q    <= '0;
         wel_q     <= 1'b0;
         prot_q    <= 2'b00;
         wr_seen   <= 1'b0;
         store_q   <= 1'b0;
         recall_q  <= 1'b0;
      end else begin
         store_q  <= 1'b0;
         recall_q <= 1'b0;
         if (cs_s) begin
            phase     <= PH_OPC;
            bit_cnt   <= '0;
            out_live  <= 1'b0;
            abyte_cnt <= '0;
            if (cs_rise && wr_seen) begin
               wel_q <= 1'b0;
            end
            wr_seen <= 1'b0;
         end else begin
            if (sck_rise) begin
               bit_cnt <= bit_cnt + 3'd1;
               sh_in   <= byte_in[6:0];
            end
            if (byte_done) begin
               unique case (phase)
                  PH_OPC: begin
                     unique case (byte_in)
                        OP_WREN:   begin wel_q <= 1'b1; phase <= PH_IDLE; end
                        OP_WRDI:   begin wel_q <= 1'b0; phase <= PH_IDLE; end
                        OP_RDSR:   phase <= PH_SRD;
                        OP_WRSR:   begin phase <= PH_SRW; wr_seen <= 1'b1; end
                        OP_READ:   begin acc <= AC_READ;  phase <= PH_ADDR; end
                        OP_FREAD:  begin acc <= AC_FREAD; phase <= PH_ADDR; end
                        OP_WRITE:  begin acc <= AC_WRITE; phase <= PH_ADDR; wr_seen <= 1'b1; end
                        OP_STORE:  begin store_q  <= 1'b1; phase <= PH_IDLE; end
                        OP_RECALL: begin recall_q <= 1'b1; phase <= PH_IDLE; end
                        default:   phase <= PH_IDLE;
                     endcase
                  end
                  PH_ADDR: begin
                     addr_q    <= AW'({addr_q, byte_in});
                     abyte_cnt <= abyte_cnt + 2'd1;
                     if (abyte_cnt == 2'd2) begin
                        unique case (acc)
                           AC_READ:  phase <= PH_RDATA;
                           AC_FREAD: phase <= PH_DUMMY;
                           default:  phase <= PH_WDATA;
                        endcase
                     end
                  end
                  PH_DUMMY: phase <= PH_RDATA;
                  PH_WDATA: addr_q <= addr_q + 1'b1;
                  PH_RDATA: addr_q <= addr_q + 1'b1;
                  PH_SRW: begin
                     if (wel_q && wp_s) begin
                        prot_q <= byte_in[3:2];
                     end
                     phase <= PH_IDLE;
                  end
                  default: ;
               endcase
            end
            if (sck_fall && out_phase) begin
               if (bit_cnt == 3'd0) begin
                  out_sh   <= (phase == PH_RDATA) ? mem_rdata : status;
                  out_live <= 1'b1;
               end else begin
                  out_sh <= {out_sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign so_o         = out_sh[7];
   assign so_oe_o      = out_live && active && out_phase;
   assign store_req_o  = store_q;
   assign recall_req_o = recall_q;

   // R11
   cs_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_rise |=> (phase == PH_OPC) && (bit_cnt == 3'd0));

   // R2
   addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_inc |=> (addr_q == AW'($past(addr_q) + 1'b1)));

   // R3
   addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_inc && addr_q == ADDR_TOP) |=> (addr_q == '0));

   // R10
   hold_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_s && !cs_s) |=> ($stable(bit_cnt) && $stable(phase) && $stable(out_sh) && $stable(addr_q)));

   // R12
   so_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      so_oe_o |-> (!cs_s && hold_s));

   // R6
   wrdi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_done && phase == PH_OPC && byte_in == OP_WRDI) |=> !wel_q);

   // R13
   store_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      store_req_o |=> !store_req_o);

endmodule

// File: tb/sram_spi_slave_tb_top.sv
module sram_spi_slave_tb_top;

   localparam int AW = 8;
   localparam int N  = 1 << AW;
   localparam int H  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe, store_req, recall_req;

   int   n_chk = 0, n_fail = 0;
   int   st_cnt = 0, rc_cnt = 0;
   bit   cpol = 1'b0;
   bit   done = 1'b0;
   logic oe_all, oe_any;
   logic [7:0] exp_mem [N];
   logic [7:0] rx, rx2;

   always #2.5ns clk = ~clk;

   sram_spi_slave #(.ADDR_W(AW), .SYNC_STAGES(1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
      .hold_ni(hold_n), .wp_ni(wp_n), .so_o(so), .so_oe_o(so_oe),
      .store_req_o(store_req), .recall_req_o(recall_req));

   always @(posedge clk) begin
      if (store_req)  st_cnt++;
      if (recall_req) rc_cnt++;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int k, input int a);
      return 8'((a * (2 * k + 1)) + 8'h35 + k * 17);
   endfunction

   function automatic bit locked(input int p, input int a);
      case (p)
         0:       return 1'b0;
         1:       return a >= (3 * N) / 4;
         2:       return a >= N / 2;
         default: return 1'b1;
      endcase
   endfunction

   task automatic bits_io(input logic [7:0] tx, input int nb, output logic [7:0] din);
      din = '0;
      oe_all = 1'b1;
      oe_any = 1'b0;
      for (int i = 7; i > 7 - nb; i--) begin
         sck = 1'b0;
         si  = tx[i];
         idle(H);
         din[i] = so;
         oe_all &= so_oe;
         oe_any |= so_oe;
         sck = 1'b1;
         idle(H);
      end
   endtask

   task automatic xb(input logic [7:0] tx, output logic [7:0] din);
      bits_io(tx, 8, din);
   endtask

   task automatic cs_lo();
      sck = cpol;
      idle(H);
      cs_n = 1'b0;
      idle(H);
   endtask

   task automatic cs_hi();
      if (!cpol) sck = 1'b0;
      idle(H);
      cs_n = 1'b1;
      idle(2 * H);
   endtask

   task automatic set_mode(input bit m);
      cpol = m;
      sck  = m;
      idle(2 * H);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      cs_lo();
      xb(op, d);
      cs_hi();
   endtask

   task automatic send_addr(input int a);
      logic [7:0] d;
      xb(8'h7E, d);
      xb(8'h81, d);
      xb(8'(a), d);
   endtask

   task automatic rd_status(input string req, input logic [7:0] exp);
      logic [7:0] d;
      cs_lo();
      xb(8'h05, d);
      xb(8'h00, rx);
      chk(rx == exp && oe_all, req, rx, exp);
      xb(8'h00, rx2);
      chk(rx2 == exp, req, rx2, exp);
      cs_hi();
   endtask

   task automatic wr_burst(input int start, input int n, input int k, input bit wel, input int p);
      logic [7:0] d;
      cs_lo();
      xb(8'h02, d);
      send_addr(start);
      for (int j = 0; j < n; j++) begin
         int a = (start + j) % N;
         xb(pat(k, a), d);
         if (wel && !locked(p, a)) exp_mem[a] = pat(k, a);
      end
      cs_hi();
   endtask

   task automatic rd_burst(input int start, input int n, input bit fast, input string req);
      logic [7:0] d;
      cs_lo();
      xb(fast ? 8'h0B : 8'h03, d);
      send_addr(start);
      if (fast) begin
         xb(8'h00, d);
         chk(!oe_any, "R4 dummy byte SO undriven", oe_any, 0);
      end
      for (int j = 0; j < n; j++) begin
         int a = (start + j) % N;
         xb(8'h00, rx);
         chk(rx == exp_mem[a] && oe_all, req, rx, exp_mem[a]);
      end
      cs_hi();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired before end of sequence");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      for (int a = 0; a < N; a++) exp_mem[a] = '0;
      idle(4);
      rst_n = 1'b1;
      idle(4);

      // R1 reset state
      chk(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
      chk(st_cnt == 0 && rc_cnt == 0, "R1 no request after reset", st_cnt + rc_cnt, 0);
      rd_status("R1 status after reset", 8'h00);

      // R2 / R6 full-array burst write with wrap, mode 0
      set_mode(1'b0);
      cmd(8'h06);
      rd_status("R6 r7_ wel set by 0x06", 8'h02);
      cmd(8'h06);
      wr_burst(N - 16, N, 1, 1'b1, 0);
      rd_status("R6 wel cleared by end of write", 8'h00);

      // R3 / R5 full read in mode 3
      set_mode(1'b1);
      rd_burst(0, N, 1'b0, "R3 r5_ read mode 3");

      // R4 fast read across the wrap, mode 0
      set_mode(1'b0);
      rd_burst(N - 2, 4, 1'b1, "R4 fast read wrap");

      // R6 write without the latch
      wr_burst(16, 1, 9, 1'b0, 0);
      rd_burst(16, 1, 1'b0, "R6 write ignored without wel");

      // R6 latch cleared by 0x04
      cmd(8'h06);
      cmd(8'h04);
      rd_status("R6 wel cleared by 0x04", 8'h00);
      wr_burst(17, 1, 9, 1'b0, 0);
      rd_burst(17, 1, 1'b0, "R6 write ignored after 0x04");

      // R7 / R8 protect levels
      for (int p = 1; p < 4; p++) begin
         set_mode(p[0]);
         cmd(8'h06);
         cs_lo();
         xb(8'h01, d);
         xb(8'(p << 2), d);
         cs_hi();
         rd_status("R7 prot bits loaded", 8'(p << 2));
         cmd(8'h06);
         wr_burst(0, N, p + 2, 1'b1, p);
         rd_burst(0, N, 1'b0, "R8 protected region");
      end
      set_mode(1'b0);
      cmd(8'h06);
      cs_lo();
      xb(8'h01, d);
      xb(8'h00, d);
      cs_hi();
      rd_status("R7 prot cleared", 8'h00);

      // R9 wp_n locks the status byte
      wp_n = 1'b0;
      cmd(8'h06);
      cs_lo();
      xb(8'h01, d);
      xb(8'h0C, d);
      cs_hi();
      rd_status("R9 status write blocked", 8'h00);
      wp_n = 1'b1;

      // R10 hold in the middle of a read byte
      cs_lo();
      xb(8'h03, d);
      send_addr(8'h20);
      bits_io(8'h00, 4, rx);
      sck = 1'b0;
      idle(H);
      hold_n = 1'b0;
      idle(H);
      chk(so_oe == 1'b0, "R10 SO undriven in hold", so_oe, 0);
      for (int i = 0; i < 3; i++) begin
         si = ~si;
         sck = 1'b1;
         idle(H);
         sck = 1'b0;
         idle(H);
      end
      hold_n = 1'b1;
      idle(H);
      for (int i = 3; i >= 0; i--) begin
         sck = 1'b0;
         si  = 1'b0;
         idle(H);
         rx[i] = so;
         sck = 1'b1;
         idle(H);
      end
      chk(rx == exp_mem[8'h20], "R10 byte intact across hold", rx, exp_mem[8'h20]);
      xb(8'h00, rx);
      chk(rx == exp_mem[8'h21], "R10 burst continues after hold", rx, exp_mem[8'h21]);
      cs_hi();

      // R11 partial opcode and partial data byte
      cs_lo();
      bits_io(8'h06, 5, d);
      cs_hi();
      rd_status("R11 partial opcode ignored", 8'h00);
      cmd(8'h06);
      cs_lo();
      xb(8'h02, d);
      send_addr(8'h30);
      xb(8'h5A, d);
      bits_io(8'hFF, 5, d);
      cs_hi();
      exp_mem[8'h30] = 8'h5A;
      rd_burst(8'h30, 2, 1'b0, "R11 partial data byte dropped");

      // R12 unknown opcode
      cs_lo();
      xb(8'hA5, d);
      chk(!oe_any, "R12 SO undriven on opcode", oe_any, 0);
      xb(8'h05, d);
      chk(!oe_any, "R12 SO undriven after unknown opcode", oe_any, 0);
      xb(8'h03, d);
      chk(!oe_any, "R12 still undriven", oe_any, 0);
      cs_hi();
      rd_status("R12 normal after unknown opcode", 8'h00);

      // R13 request pulses
      cmd(8'h3C);
      chk(st_cnt == 1 && rc_cnt == 0, "R13 store pulse", st_cnt * 16 + rc_cnt, 16);
      cmd(8'h60);
      chk(st_cnt == 1 && rc_cnt == 1, "R13 recall pulse", st_cnt * 16 + rc_cnt, 17);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule